// File: doc/BRIEF.md
# Selectable System Clock Divider

This block turns one oscillator clock into two families of clock-enable pulses, both in the oscillator domain. The first is the CPU enable. It pulses once every 2, 8, 16 or 64 oscillator cycles, and the ratio is chosen by a 2-bit field of a mode register that software writes through a simple byte write port. The second is a bank of eleven binary prescaler enables. Tap n pulses once every 2^n oscillator cycles, so the taps cover divide ratios from 1 to 1024 and peripherals can pick any of them as their time base.

Two low-power conditions are decoded from a pair of control inputs, a hold bit and a low-power bit. In the stopped condition both counters freeze and every enable is held low. When the stopped condition ends, the counting resumes from the frozen phase. In the sleeping condition only the CPU enable is masked, and the prescaler keeps running. A new CPU ratio is applied only at the terminal count of the ratio in force, so the CPU never sees a shortened cycle.

Top module: `sysclk_divider`

## Requirements
- R1: The select field chooses the CPU ratio with this encoding: 00 gives 2, 01 gives 8, 10 gives 16 and 11 gives 64. With a 4 MHz oscillator these ratios give CPU cycle times of 0.5 µs, 2 µs, 4 µs and 16 µs. `cpu_en` is a one-cycle pulse once every ratio oscillator cycles.
- R2: A write with `cfg_we` high loads the select field from bits 3:2 of `cfg_wdata`. The other data bits have no effect on the ratio.
- R3: A newly written ratio takes effect at the next terminal count of the ratio in force. The CPU period that contains the write keeps the old length, and every later period has the new length.
- R4: Asynchronous reset clears both counters and selects divide by 2. During reset `cpu_en` is 0 and `tap_en` is 11'b000_0000_0001. After reset is released, `cpu_en` first pulses in oscillator cycle 1, and tap n (n ≥ 1) first pulses in cycle 2^n−1.
- R5: Tap n pulses once every 2^n running oscillator cycles. This gives a 250 ns period for tap 0 and a 256 µs period for tap 10 at 4 MHz. Tap 0 is high in every cycle that is not stopped.
- R6: A pulse on tap n is always accompanied by pulses on every tap below n.
- R7: Hold bit = 0 with low-power bit = 1 means stopped. While stopped, all taps and `cpu_en` are low and both counters hold their values. Afterwards, counting resumes so that the gaps measured in running cycles are unchanged.
- R8: Hold bit = 1 with low-power bit = 0 means sleeping. While sleeping, `cpu_en` stays low and the prescaler taps keep pulsing at their normal rates.
- R9: The two other control combinations (both 0, or both 1) give normal operation.
- R10: `cpu_en` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data; the select field is in bits 3:2 |
| ctl_hold | input | 1 | Hold control bit |
| ctl_lowpwr | input | 1 | Low-power control bit |
| cpu_en | output | 1 | CPU clock-enable pulse |
| tap_en | output | 11 | Prescaler tap enables; bit n pulses every 2^n cycles |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a CPU period. To produce it, the bench waits for a CPU pulse and issues the write one cycle later, so the write edge cannot coincide with a terminal count. It then measures the next three pulse gaps. This is repeated for all sixteen old/new ratio pairs, with different values in the unused data bits. A stop is also entered partway through a divide-by-8 period, and the bench checks that the period completes after exactly the remaining number of running cycles.

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int NTAPS   = 11,
  parameter int SEL_LSB = 2
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  input  logic             ctl_hold,
  input  logic             ctl_lowpwr,
  output logic             cpu_en,
  output logic [NTAPS-1:0] tap_en
);
  localparam int PSW = NTAPS - 1;
  localparam int CW  = 6;

  logic          stop, sleep, cpu_tc;
  logic [1:0]    sel_reg, sel_act;
  logic [CW-1:0] cpu_cnt, cpu_last;
  logic [PSW-1:0] ps_cnt;

  assign stop  = ~ctl_hold & ctl_lowpwr;
  assign sleep = ctl_hold & ~ctl_lowpwr;

  always_comb begin
    case (sel_act)
      2'b00:   cpu_last = CW'(1);
      2'b01:   cpu_last = CW'(7);
      2'b10:   cpu_last = CW'(15);
      default: cpu_last = CW'(63);
    endcase
  end

  assign cpu_tc = (cpu_cnt == cpu_last);
  assign cpu_en = cpu_tc & ~stop & ~sleep;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      sel_reg <= 2'b00;
      sel_act <= 2'b00;
      cpu_cnt <= '0;
      ps_cnt  <= '0;
    end else begin
      if (cfg_we) sel_reg <= cfg_wdata[SEL_LSB +: 2];
      if (!stop) begin
        ps_cnt <= ps_cnt + PSW'(1);
        if (cpu_tc) begin
          cpu_cnt <= '0;
          sel_act <= sel_reg;
        end else begin
          cpu_cnt <= cpu_cnt + CW'(1);
        end
      end
    end
  end

  assign tap_en[0] = ~stop;
  for (genvar n = 1; n < NTAPS; n++) begin : g_tap
    assign tap_en[n] = ~stop & (&ps_cnt[n-1:0]);
  end

  // R3
  sel_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(cpu_tc && !stop) |=> $stable(sel_act));
  // R6
  tap_nest_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    tap_en[NTAPS-1] |-> (&tap_en[NTAPS-2:0]));
  // R7
  stop_freeze_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    stop |=> ($stable(ps_cnt) && $stable(cpu_cnt)));
  // R8
  sleep_run_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    sleep |=> ((ps_cnt - $past(ps_cnt)) == PSW'(1)));
  // R10
  cpu_gap_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    cpu_en |=> !cpu_en);
endmodule

// File: tb/sysclk_divider_tb.sv
module sysclk_divider_tb;
  logic        clk = 0, rst_n = 0, cfg_we = 0, ctl_hold = 0, ctl_lowpwr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        cpu_en;
  logic [10:0] tap_en;
  int tests = 0, fails = 0;

  sysclk_divider u_dut (.clk_osc(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_hold(ctl_hold), .ctl_lowpwr(ctl_lowpwr), .cpu_en(cpu_en), .tap_en(tap_en));

  always #5 clk = ~clk;

  wire stop_b = !ctl_hold && ctl_lowpwr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int s);
    case (s)
      0: return 2;
      1: return 8;
      2: return 16;
      default: return 64;
    endcase
  endfunction

  bit mon_en = 0, prev_cpu = 0, cpu_seen = 0;
  int cyc = 0;
  int last_t[11];
  bit seen_t[11];

  always @(negedge clk) if (mon_en) begin
    if (cpu_en && prev_cpu) check(0, "R10 consecutive cpu_en", 1, 0);
    prev_cpu = cpu_en;
    if (stop_b) begin
      check(tap_en == 0 && !cpu_en, "R7 enables low while stopped", int'(tap_en), 0);
    end else begin
      cyc++;
      if (cpu_en && !cpu_seen) begin
        check(cyc == 1, "R4 first cpu pulse cycle", cyc, 1);
        cpu_seen = 1;
      end
      check(tap_en[0], "R5 tap0 continuous", int'(tap_en[0]), 1);
      for (int n = 0; n < 11; n++) begin
        if (tap_en[n]) begin
          if (seen_t[n]) check(cyc - last_t[n] == (1 << n), "R5 tap gap", cyc - last_t[n], 1 << n);
          else if (n > 0) check(cyc == (1 << n) - 1, "R4 first tap pulse", cyc, (1 << n) - 1);
          seen_t[n] = 1;
          last_t[n] = cyc;
          if (n > 0 && !tap_en[n-1]) check(0, "R6 tap nesting", n, n - 1);
        end
      end
    end
  end

  task automatic collect(input bit do_wr, input logic [7:0] wd, output int g0, output int g1, output int g2);
    int k = 0, last = 0, got = 0;
    do @(negedge clk); while (!cpu_en);
    while (got < 3) begin
      @(negedge clk);
      k++;
      if (k == 1 && do_wr) begin cfg_wdata = wd; cfg_we = 1; end
      else cfg_we = 0;
      if (cpu_en) begin
        case (got)
          0: g0 = k - last;
          1: g1 = k - last;
          default: g2 = k - last;
        endcase
        last = k;
        got++;
      end
    end
  endtask

  initial begin
    int g0, g1, g2, cnt, run;
    #8;
    check(cpu_en == 0, "R4 reset cpu_en", int'(cpu_en), 0);
    check(tap_en == 11'h001, "R4 reset taps", int'(tap_en), 1);
    #4 rst_n = 1; mon_en = 1;
    repeat (1100) @(negedge clk);
    collect(0, 8'h00, g0, g1, g2);
    check(g1 == 2 && g2 == 2, "R1 default ratio 2", g2, 2);

    for (int o = 0; o < 4; o++) begin
      for (int nw = 0; nw < 4; nw++) begin
        logic [7:0] wo, wn;
        wo = {4'(o * 5 + nw), 2'(o), 2'(nw)};
        wn = {4'(15 - nw * 3), 2'(nw), 2'(o + 1)};
        collect(1, wo, g0, g1, g2);
        collect(0, 8'h00, g0, g1, g2);
        check(g2 == ratio(o), "R2 R1 ratio from bits 3:2", g2, ratio(o));
        collect(1, wn, g0, g1, g2);
        check(g0 == ratio(o), "R3 write period keeps old length", g0, ratio(o));
        check(g1 == ratio(nw), "R3 next period has new length", g1, ratio(nw));
        check(g2 == ratio(nw), "R1 steady new ratio", g2, ratio(nw));
      end
    end

    collect(1, 8'h04, g0, g1, g2);
    collect(0, 8'h00, g0, g1, g2);
    check(g2 == 8, "R1 ratio 8 before stop", g2, 8);
    do @(negedge clk); while (!cpu_en);
    repeat (3) @(negedge clk);
    ctl_hold = 0; ctl_lowpwr = 1;
    cnt = 0;
    repeat (50) begin @(negedge clk); if (cpu_en) cnt++; end
    check(cnt == 0, "R7 no cpu pulse while stopped", cnt, 0);
    ctl_lowpwr = 0;
    run = 3;
    do begin @(negedge clk); run++; end while (!cpu_en);
    check(run == 8, "R7 phase resumes after stop", run, 8);

    ctl_hold = 1; ctl_lowpwr = 0;
    cnt = 0; run = 0;
    repeat (512) begin @(negedge clk); if (cpu_en) cnt++; if (tap_en[1]) run++; end
    check(cnt == 0, "R8 cpu_en low while sleeping", cnt, 0);
    check(run == 256, "R8 prescaler runs while sleeping", run, 256);

    ctl_hold = 1; ctl_lowpwr = 1;
    collect(0, 8'h00, g0, g1, g2);
    check(g1 == 8 && g2 == 8, "R9 both-high runs normally", g2, 8);
    ctl_hold = 0; ctl_lowpwr = 0;
    collect(0, 8'h00, g0, g1, g2);
    check(g1 == 8 && g2 == 8, "R9 both-low runs normally", g2, 8);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule